// File: doc/BRIEF.md
# Strobed Byte Writer for a Parallel MIDI Link

This block is the host-side sender on a one-way parallel link to an external MIDI interface. Messages arrive as a valid/ready stream of bytes. The first byte of a message carries a start marker and the final byte carries an end marker. When a message starts, the block holds its first byte on the output bus and waits for the peripheral to signal that it can take data. The peripheral's ready line reaches the host inverted, so it is active low at this block's pin, and it passes through a short synchronizer before the block sees it. The block then writes every byte of the message in order. For each byte it first places the value on the 8-bit output bus and then drives an active-low write strobe for a set number of cycles.

Readiness is tested only where a message begins. The bytes after the first follow with strobe pulses alone, even if the ready line drops in between. If readiness does not arrive within a set number of cycles, the block raises an error flag that stays set, throws away the rest of that message, and goes back to idle. Parameters set the strobe low width and the minimum high gap in clock cycles, so pulses of a few microseconds need only the right counts. Back-pressure is simple: `in_ready` is high only when the block can take a byte. That is in idle, between two bytes of a message, or while it throws away the rest of a failed message. A byte transfers on any rising edge where both `in_valid` and `in_ready` are high.

Top module: `strobe_byte_writer`

## Requirements
- R1: After reset, `wr_strobe_n` is 1, `bus_data` is 0, `timeout_err` is 0 and `in_ready` is 1. A new reset clears `timeout_err`.
- R2: In idle, a byte taken without `in_first` set is dropped. It causes no strobe pulse and leaves `bus_data` unchanged.
- R3: The first byte of a message is not written while the peer is not ready. `peer_ready_n` is active low (0 means ready) and reaches the control logic through SYNC_STAGES register stages.
- R4: The first byte is taken on edge E0. If the synchronized ready is not seen at any of edges E1 to E(TIMEOUT_CYC), `timeout_err` goes to 1 at edge E(TIMEOUT_CYC). If ready is seen on that final edge, the byte is written and no error is raised. Once set, `timeout_err` stays 1 until reset.
- R5: After a timeout, the bytes still to come in that message are taken and dropped up to and including the one with `in_last`. Then the block is idle again.
- R6: Each byte is on `bus_data` for at least one full cycle before `wr_strobe_n` falls. `wr_strobe_n` stays low for exactly PULSE_CYC cycles.
- R7: `bus_data` does not change while `wr_strobe_n` is low.
- R8: Between two strobe pulses, `wr_strobe_n` is high for at least GAP_CYC+2 cycles.
- R9: Within a message, ready is not tested again. Bytes after the first are written even when `peer_ready_n` is 1.
- R10: Once the pulse for a byte carrying `in_last` has ended, the next message waits for ready again.
- R11: `in_ready` is 0 while waiting for ready, during the setup cycle, and while the strobe is low or in its gap.
- R12: Bytes appear on the strobe in the order they were taken, with their values unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Upstream byte valid |
| in_ready | output | 1 | Block can take a byte this cycle |
| in_data | input | DATA_W | Upstream byte |
| in_first | input | 1 | Byte starts a message |
| in_last | input | 1 | Byte ends a message |
| bus_data | output | DATA_W | Data lines toward the peripheral |
| wr_strobe_n | output | 1 | Write strobe, active low |
| peer_ready_n | input | 1 | Peripheral ready for data, active low as seen by the host |
| timeout_err | output | 1 | Sticky flag: ready did not arrive in time |

## Verification
The ready line being seen and the timeout expiring can fall on the same clock edge, the last cycle of the wait. The bench lowers `peer_ready_n` at a chosen distance from the edge that took the first byte. In one case the synchronized ready lands exactly on the final wait edge; in the other it lands one edge later. In the first case, a correct design produces a strobe pulse carrying the held byte and keeps `timeout_err` at 0. In the second, `timeout_err` must rise on exactly that edge, no pulse must appear, and the rest of the message must be taken and dropped.

// File: rtl/sbw_pkg.sv
package sbw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WAIT  = 3'd1,
    ST_SETUP = 3'd2,
    ST_LOW   = 3'd3,
    ST_HIGH  = 3'd4,
    ST_NEXT  = 3'd5,
    ST_DROP  = 3'd6
  } wr_state_t;

endpackage

// File: rtl/sbw_rdy_sync.sv
module sbw_rdy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic peer_ready_n,
  output logic ready
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= ~peer_ready_n;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], ~peer_ready_n};
      end
    end
  endgenerate

  assign ready = chain_q[STAGES-1];
endmodule

// File: rtl/sbw_cycle_timer.sv
module sbw_cycle_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (dec)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/strobe_byte_writer.sv
module strobe_byte_writer
  import sbw_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int PULSE_CYC   = 400,
  parameter int GAP_CYC     = 400,
  parameter int TIMEOUT_CYC = 200000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_first,
  input  logic              in_last,
  output logic [DATA_W-1:0] bus_data,
  output logic              wr_strobe_n,
  input  logic              peer_ready_n,
  output logic              timeout_err
);
  localparam int MAX_PG = (PULSE_CYC > GAP_CYC) ? PULSE_CYC : GAP_CYC;
  localparam int MAX_C  = (MAX_PG > TIMEOUT_CYC) ? MAX_PG : TIMEOUT_CYC;
  localparam int CNT_W  = $clog2(MAX_C + 1);

  localparam logic [CNT_W-1:0] TMO_LD   = CNT_W'(TIMEOUT_CYC - 1);
  localparam logic [CNT_W-1:0] PULSE_LD = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] GAP_LD   = CNT_W'(GAP_CYC - 1);

  wr_state_t         st_q, st_d;
  logic [DATA_W-1:0] bus_q;
  logic              last_q;
  logic              err_q;
  logic              peer_rdy;
  logic              tmr_load, tmr_dec, tmr_zero;
  logic [CNT_W-1:0]  tmr_val;
  logic              take, set_err;

  sbw_rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk          (clk),
    .rst_n        (rst_n),
    .peer_ready_n (peer_ready_n),
    .ready        (peer_rdy)
  );

  sbw_cycle_timer #(.W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .dec      (tmr_dec),
    .zero     (tmr_zero)
  );

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    tmr_dec  = 1'b0;
    in_ready = 1'b0;
    take     = 1'b0;
    set_err  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        in_ready = 1'b1;
        if (in_valid && in_first) begin
          take     = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = TMO_LD;
          st_d     = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (peer_rdy) begin
          st_d = ST_SETUP;
        end else if (tmr_zero) begin
          set_err = 1'b1;
          st_d    = last_q ? ST_IDLE : ST_DROP;
        end else begin
          tmr_dec = 1'b1;
        end
      end
      ST_SETUP: begin
        tmr_load = 1'b1;
        tmr_val  = PULSE_LD;
        st_d     = ST_LOW;
      end
      ST_LOW: begin
        if (tmr_zero) begin
          tmr_load = 1'b1;
          tmr_val  = GAP_LD;
          st_d     = ST_HIGH;
        end else begin
          tmr_dec = 1'b1;
        end
      end
      ST_HIGH: begin
        if (tmr_zero) st_d = last_q ? ST_IDLE : ST_NEXT;
        else          tmr_dec = 1'b1;
      end
      ST_NEXT: begin
        in_ready = 1'b1;
        if (in_valid) begin
          take = 1'b1;
          st_d = ST_SETUP;
        end
      end
      ST_DROP: begin
        in_ready = 1'b1;
        if (in_valid && in_last) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      bus_q  <= '0;
      last_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (take) begin
        bus_q  <= in_data;
        last_q <= in_last;
      end
      if (set_err) err_q <= 1'b1;
    end
  end

  assign bus_data    = bus_q;
  assign wr_strobe_n = (st_q != ST_LOW);
  assign timeout_err = err_q;
endmodule

// File: rtl/sbw_checker.sv
module sbw_checker #(
  parameter int DATA_W    = 8,
  parameter int PULSE_CYC = 400,
  parameter int GAP_CYC   = 400
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic [DATA_W-1:0] bus_data,
  input logic              wr_strobe_n,
  input logic              timeout_err
);
  int unsigned lo_cnt;
  int unsigned hi_cnt;
  logic        seen_pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt     <= 0;
      hi_cnt     <= 0;
      seen_pulse <= 1'b0;
    end else begin
      if (!wr_strobe_n) begin
        lo_cnt     <= lo_cnt + 1;
        hi_cnt     <= 0;
        seen_pulse <= 1'b1;
      end else begin
        lo_cnt <= 0;
        if (hi_cnt != 32'hFFFF_FFFF) hi_cnt <= hi_cnt + 1;
      end
    end
  end

  assert_pulse_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_strobe_n) |-> lo_cnt == PULSE_CYC);

  assert_bus_settled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_strobe_n) |-> $stable(bus_data));

  assert_bus_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_strobe_n && !$past(wr_strobe_n)) |-> $stable(bus_data));

  assert_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(wr_strobe_n) && seen_pulse) |-> hi_cnt >= (GAP_CYC + 2));

  assert_busy_not_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_strobe_n |-> !in_ready);

  assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |=> timeout_err);
endmodule

bind strobe_byte_writer sbw_checker #(
  .DATA_W    (DATA_W),
  .PULSE_CYC (PULSE_CYC),
  .GAP_CYC   (GAP_CYC)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_ready    (in_ready),
  .bus_data    (bus_data),
  .wr_strobe_n (wr_strobe_n),
  .timeout_err (timeout_err)
);

// File: tb/tb_strobe_byte_writer.sv
`timescale 1ns/1ps
module tb_strobe_byte_writer;
  localparam int P = 3;
  localparam int G = 2;
  localparam int T = 20;
  localparam int S = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       in_first = 1'b0;
  logic       in_last = 1'b0;
  logic [7:0] bus_data;
  logic       wr_strobe_n;
  logic       peer_ready_n = 1'b1;
  logic       timeout_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  strobe_byte_writer #(
    .DATA_W(8), .PULSE_CYC(P), .GAP_CYC(G), .TIMEOUT_CYC(T), .SYNC_STAGES(S)
  ) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_first(in_first), .in_last(in_last),
    .bus_data(bus_data), .wr_strobe_n(wr_strobe_n),
    .peer_ready_n(peer_ready_n), .timeout_err(timeout_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // pulse monitor, sampled on falling clock edges
  logic [7:0] pulses [0:255];
  int   np = 0;
  logic prev_strb = 1'b1;
  logic [7:0] prev_bus = '0;
  logic [7:0] cap = '0;
  int   lo_run = 0;
  int   hi_run = 0;
  bit   seen = 1'b0;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_strb = 1'b1; lo_run = 0; hi_run = 0; seen = 1'b0;
    end else begin
      if (prev_strb && !wr_strobe_n) begin
        check(bus_data == prev_bus, "R6 setup", bus_data, prev_bus);
        if (seen) check(hi_run >= G + 2, "R8 gap", hi_run, G + 2);
        cap = bus_data;
        pulses[np[7:0]] = bus_data;
        np++;
        lo_run = 1;
        seen = 1'b1;
        check(!in_ready, "R11 busy", in_ready, 0);
      end else if (!wr_strobe_n) begin
        lo_run++;
        check(bus_data == cap, "R7 stable", bus_data, cap);
        check(!in_ready, "R11 busy", in_ready, 0);
      end else if (!prev_strb) begin
        check(lo_run == P, "R6 width", lo_run, P);
        hi_run = 1;
      end else begin
        hi_run++;
      end
      prev_strb = wr_strobe_n;
      prev_bus  = bus_data;
    end
  end

  task automatic send_byte(input logic [7:0] d, input bit f, input bit l);
    in_valid = 1'b1; in_data = d; in_first = f; in_last = l;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
  endtask

  task automatic wait_pulses(input int n, input int limit);
    for (int k = 0; k < limit && np < n; k++) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
    end
  end

  initial begin
    int base;
    logic [7:0] b;
    logic [7:0] hold;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check(wr_strobe_n == 1'b1, "R1 strobe", wr_strobe_n, 1);
    check(bus_data == 8'h00, "R1 bus", bus_data, 0);
    check(timeout_err == 1'b0, "R1 err", timeout_err, 0);
    check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);

    // R12 sweep of lengths and patterns with the peer ready
    peer_ready_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int len = 1; len <= 4; len++) begin
      for (int pat = 0; pat < 4; pat++) begin
        base = np;
        for (int i = 0; i < len; i++) begin
          b = 8'((len * 37 + i * 53 + pat * 101) & 255);
          send_byte(b, i == 0, i == len - 1);
        end
        wait_pulses(base + len, 200);
        check(np == base + len, "R12 count", np - base, len);
        for (int i = 0; i < len; i++) begin
          b = 8'((len * 37 + i * 53 + pat * 101) & 255);
          check(pulses[8'(base + i)] == b, "R12 value", pulses[8'(base + i)], b);
        end
      end
    end
    check(timeout_err == 1'b0, "R4 no error when ready", timeout_err, 0);

    // R2 stray byte in idle is dropped
    repeat (3) @(negedge clk);
    base = np; hold = bus_data;
    send_byte(8'h5A, 1'b0, 1'b1);
    repeat (15) @(negedge clk);
    check(np == base, "R2 no pulse", np - base, 0);
    check(bus_data == hold, "R2 bus kept", bus_data, hold);

    // R9 ready dropped inside a message
    base = np;
    send_byte(8'hC1, 1'b1, 1'b0);
    wait_pulses(base + 1, 100);
    peer_ready_n = 1'b1;
    repeat (4) @(negedge clk);
    send_byte(8'hC2, 1'b0, 1'b0);
    send_byte(8'hC3, 1'b0, 1'b1);
    wait_pulses(base + 3, 100);
    check(np == base + 3, "R9 count", np - base, 3);
    check(pulses[8'(base + 2)] == 8'hC3, "R9 value", pulses[8'(base + 2)], 8'hC3);

    // R3 / R10 next message waits for ready again
    repeat (4) @(negedge clk);
    base = np;
    send_byte(8'h3C, 1'b1, 1'b1);
    repeat (10) @(negedge clk);
    check(np == base, "R3 held while not ready", np - base, 0);
    check(in_ready == 1'b0, "R11 waiting", in_ready, 0);
    peer_ready_n = 1'b0;
    wait_pulses(base + 1, 50);
    check(np == base + 1 && pulses[8'(base)] == 8'h3C, "R10 sent after ready",
          pulses[8'(base)], 8'h3C);
    check(timeout_err == 1'b0, "R4 no error", timeout_err, 0);

    // R4 ready lands on the final wait edge: it wins
    peer_ready_n = 1'b1;
    repeat (6) @(negedge clk);
    base = np;
    send_byte(8'hA7, 1'b1, 1'b1);
    repeat (T - 3) @(posedge clk);
    @(negedge clk);
    peer_ready_n = 1'b0;
    wait_pulses(base + 1, 50);
    check(np == base + 1, "R4 ready on last edge wins", np - base, 1);
    check(timeout_err == 1'b0, "R4 no error on last edge", timeout_err, 0);

    // R4 / R5 ready one edge late: timeout, rest of message dropped
    peer_ready_n = 1'b1;
    repeat (6) @(negedge clk);
    base = np;
    send_byte(8'h11, 1'b1, 1'b0);
    repeat (T - 2) @(posedge clk);
    @(negedge clk);
    peer_ready_n = 1'b0;
    @(posedge clk); @(negedge clk);
    check(timeout_err == 1'b0, "R4 not yet expired", timeout_err, 0);
    @(posedge clk); @(negedge clk);
    check(timeout_err == 1'b1, "R4 expired", timeout_err, 1);
    send_byte(8'h22, 1'b0, 1'b0);
    send_byte(8'h33, 1'b0, 1'b1);
    repeat (20) @(negedge clk);
    check(np == base, "R5 dropped", np - base, 0);
    check(in_ready == 1'b1, "R5 idle again", in_ready, 1);
    send_byte(8'h44, 1'b1, 1'b1);
    wait_pulses(base + 1, 50);
    check(np == base + 1 && pulses[8'(base)] == 8'h44, "R5 next message sent",
          pulses[8'(base)], 8'h44);
    check(timeout_err == 1'b1, "R4 sticky", timeout_err, 1);

    // R1 reset clears the flag
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    check(timeout_err == 1'b0, "R1 err cleared", timeout_err, 0);
    check(bus_data == 8'h00, "R1 bus cleared", bus_data, 0);

    done = 1'b1;
    finish_run();
  end
endmodule